// File: doc/BRIEF.md
# Toggle-Mask Interrupt Controller with Cascaded Flag Register

This block merges sixteen level-sensitive interrupt lines into one interrupt request for a processor. Each line is copied into a pending register every cycle. A mask register selects which pending lines may raise the request. Software writes the mask by toggling: every 1 in the write data inverts the matching enable bit, and every 0 leaves that bit alone. Software clears pending bits by writing 1s to the pending register. Because the sources are levels, a source that is still active sets its bit again one cycle after the clear.

A second, smaller flag register collects two further level sources. They sit at sparse bit positions, two places apart from bit 8 upward. The flag register is cleared by writing 1s in the same way. While any of its bits is set it drives primary line 1, so the two further sources reach the processor through the main controller.

Register access uses a plain single-cycle bus. Writes take effect at the clock edge. A read returns, one cycle later with a valid strobe, the value the register held before any write made in the same cycle. The bus has no back-pressure: the block accepts a read or a write in every cycle.

Top module: `tgl_irq_ctrl`

## Requirements
- R1: After reset the pending register, the mask register and the flag register all read 0, and `cpu_irq` is low.
- R2: Pending bit n equals the level of line n at the previous clock edge: it is 1 when the line was high and 0 when the line was low. Line 1 is taken as high while any flag bit is set.
- R3: `cpu_irq` is high exactly when at least one bit is set in both the pending register and the mask register.
- R4: A write to the pending register (address 0xF000) clears, at that edge, every pending bit whose write-data bit is 1. A source that stays high sets its bit again at the next edge.
- R5: A write to the mask register (address 0xF010) replaces the mask with the old mask XOR the write data (bits 15:0).
- R6: A read sets `bus_rvalid` in the next cycle, and `bus_rdata` then carries the register value from before the read edge. Reading the pending register leaves it unchanged.
- R7: Further source n (n = 0 or 1) is copied into flag bit 8 + 2n (0x100 or 0x400) at each edge. All other flag bits read 0. The flag register is at address 0xF230.
- R8: A write to the flag register clears, at that edge, the flag bits whose write-data bit is 1. The other flag bits keep following their sources.
- R9: While any flag bit is set, pending bit 1 is set at the next edge, unless that edge also clears bit 1.
- R10: A write to any other address changes no register, and a read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 16 | Primary level interrupt sources |
| sub_irq | input | 2 | Further level sources gathered in the flag register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 16 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when bus_rvalid is high |
| bus_rvalid | output | 1 | High one cycle after a read strobe |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that the interrupt sources and the bus strobes change only between clock edges and are held low during reset. They also assume that a clear and a still-active source may meet at the same edge, and that the clear then wins for that edge only. The bench drives every input on the falling edge and holds all sources low while reset is applied. In its random phase it lets reads, writes, clears and source changes fall on the same cycle, so that the clear-wins and read-before-write orderings are exercised on purpose and not avoided.

// File: rtl/ictl_pkg.sv
package ictl_pkg;
  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_PEND  = 2'd1,
    SEL_MASK  = 2'd2,
    SEL_FLAGS = 2'd3
  } ictl_sel_e;
endpackage

// File: rtl/ictl_regdec.sv
module ictl_regdec
  import ictl_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int PEND_OFS = 16'hF000,
  parameter int MASK_OFS = 16'hF010,
  parameter int FLAG_OFS = 16'hF230
) (
  input  logic [ADDR_W-1:0] addr,
  output ictl_sel_e         sel
);
  localparam logic [ADDR_W-1:0] PendA = ADDR_W'(PEND_OFS);
  localparam logic [ADDR_W-1:0] MaskA = ADDR_W'(MASK_OFS);
  localparam logic [ADDR_W-1:0] FlagA = ADDR_W'(FLAG_OFS);

  always_comb begin
    if (addr == PendA)      sel = SEL_PEND;
    else if (addr == MaskA) sel = SEL_MASK;
    else if (addr == FlagA) sel = SEL_FLAGS;
    else                    sel = SEL_NONE;
  end
endmodule

// File: rtl/ictl_cascade.sv
module ictl_cascade #(
  parameter int DATA_W      = 32,
  parameter int NUM_SUB     = 2,
  parameter int FLAG_BASE   = 8,
  parameter int FLAG_STRIDE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SUB-1:0] sub_irq,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] clr_data,
  output logic [DATA_W-1:0] flags_q,
  output logic              any_flag
);
  localparam int TopBit = FLAG_BASE + FLAG_STRIDE * (NUM_SUB - 1);

  initial begin
    if (TopBit >= DATA_W) $error("flag positions exceed data width");
  end

  logic [DATA_W-1:0] set_vec;
  logic [DATA_W-1:0] kill_vec;

  always_comb begin
    set_vec = '0;
    for (int n = 0; n < NUM_SUB; n++) begin
      set_vec[FLAG_BASE + FLAG_STRIDE * n] = sub_irq[n];
    end
  end

  assign kill_vec = clr_en ? clr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= set_vec & ~kill_vec;
  end

  assign any_flag = |flags_q;
endmodule

// File: rtl/ictl_pending.sv
module ictl_pending #(
  parameter int NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lines,
  input  logic                 clr_en,
  input  logic [NUM_LINES-1:0] clr_data,
  input  logic                 tgl_en,
  input  logic [NUM_LINES-1:0] tgl_data,
  output logic [NUM_LINES-1:0] pend_q,
  output logic [NUM_LINES-1:0] mask_q,
  output logic                 any_enabled
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic drop;
    assign drop = clr_en & clr_data[g];
    always_ff @(posedge clk) begin
      if (!rst_n) pend_q[g] <= 1'b0;
      else        pend_q[g] <= lines[g] & ~drop;
    end
    always_ff @(posedge clk) begin
      if (!rst_n)                    mask_q[g] <= 1'b0;
      else if (tgl_en && tgl_data[g]) mask_q[g] <= ~mask_q[g];
    end
  end

  assign any_enabled = |(pend_q & mask_q);
endmodule

// File: rtl/tgl_irq_ctrl.sv
module tgl_irq_ctrl
  import ictl_pkg::*;
#(
  parameter int NUM_LINES    = 16,
  parameter int NUM_SUB      = 2,
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 32,
  parameter int CASCADE_LINE = 1,
  parameter int FLAG_BASE    = 8,
  parameter int FLAG_STRIDE  = 2,
  parameter int PEND_OFS     = 16'hF000,
  parameter int MASK_OFS     = 16'hF010,
  parameter int FLAG_OFS     = 16'hF230
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic [NUM_SUB-1:0]   sub_irq,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 bus_rvalid,
  output logic                 cpu_irq
);
  ictl_sel_e            sel;
  logic [NUM_LINES-1:0] pend_q;
  logic [NUM_LINES-1:0] mask_q;
  logic [DATA_W-1:0]    flags_q;
  logic                 any_flag;
  logic [NUM_LINES-1:0] lines_eff;
  logic [NUM_LINES-1:0] casc_vec;
  logic [DATA_W-1:0]    pend_ext;
  logic [DATA_W-1:0]    mask_ext;
  logic [DATA_W-1:0]    rd_mux;

  ictl_regdec #(
    .ADDR_W(ADDR_W), .PEND_OFS(PEND_OFS), .MASK_OFS(MASK_OFS), .FLAG_OFS(FLAG_OFS)
  ) u_dec (
    .addr(bus_addr),
    .sel (sel)
  );

  ictl_cascade #(
    .DATA_W(DATA_W), .NUM_SUB(NUM_SUB), .FLAG_BASE(FLAG_BASE), .FLAG_STRIDE(FLAG_STRIDE)
  ) u_casc (
    .clk     (clk),
    .rst_n   (rst_n),
    .sub_irq (sub_irq),
    .clr_en  (bus_wr && sel == SEL_FLAGS),
    .clr_data(bus_wdata),
    .flags_q (flags_q),
    .any_flag(any_flag)
  );

  always_comb begin
    casc_vec = '0;
    casc_vec[CASCADE_LINE] = any_flag;
  end
  assign lines_eff = irq_lines | casc_vec;

  ictl_pending #(
    .NUM_LINES(NUM_LINES)
  ) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .lines      (lines_eff),
    .clr_en     (bus_wr && sel == SEL_PEND),
    .clr_data   (bus_wdata[NUM_LINES-1:0]),
    .tgl_en     (bus_wr && sel == SEL_MASK),
    .tgl_data   (bus_wdata[NUM_LINES-1:0]),
    .pend_q     (pend_q),
    .mask_q     (mask_q),
    .any_enabled(cpu_irq)
  );

  always_comb begin
    pend_ext = '0;
    mask_ext = '0;
    pend_ext[NUM_LINES-1:0] = pend_q;
    mask_ext[NUM_LINES-1:0] = mask_q;
    case (sel)
      SEL_PEND:  rd_mux = pend_ext;
      SEL_MASK:  rd_mux = mask_ext;
      SEL_FLAGS: rd_mux = flags_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/ictl_checker.sv
module ictl_checker #(
  parameter int NUM_LINES    = 16,
  parameter int NUM_SUB      = 2,
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 32,
  parameter int CASCADE_LINE = 1,
  parameter int PEND_OFS     = 16'hF000,
  parameter int MASK_OFS     = 16'hF010,
  parameter int FLAG_OFS     = 16'hF230
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] irq_lines,
  input logic [NUM_SUB-1:0]   sub_irq,
  input logic                 bus_wr,
  input logic                 bus_rd,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic                 bus_rvalid,
  input logic                 cpu_irq,
  input logic [NUM_LINES-1:0] pend_q,
  input logic [NUM_LINES-1:0] mask_q,
  input logic [DATA_W-1:0]    flags_q
);
  logic wr_pend, wr_mask, wr_flag, wr_other;
  assign wr_pend  = bus_wr && bus_addr == ADDR_W'(PEND_OFS);
  assign wr_mask  = bus_wr && bus_addr == ADDR_W'(MASK_OFS);
  assign wr_flag  = bus_wr && bus_addr == ADDR_W'(FLAG_OFS);
  assign wr_other = bus_wr && !wr_pend && !wr_mask && !wr_flag;

  AST_LINE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pend |=> ((pend_q & $past(irq_lines)) == $past(irq_lines))); // R2
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend |=> ((pend_q & $past(bus_wdata[NUM_LINES-1:0])) == '0)); // R4
  AST_MASK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == ($past(mask_q) ^ $past(bus_wdata[NUM_LINES-1:0])))); // R5
  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid); // R6
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_flag |=> ((flags_q & $past(bus_wdata)) == '0)); // R8
  AST_CASCADE_FEEDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((|flags_q) && !(wr_pend && bus_wdata[CASCADE_LINE])) |=> pend_q[CASCADE_LINE]); // R9
  AST_OTHER_WR_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_other |=> $stable(mask_q)); // R10
  AST_IRQ_QUIET_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !cpu_irq); // R3
endmodule

bind tgl_irq_ctrl ictl_checker #(
  .NUM_LINES(NUM_LINES), .NUM_SUB(NUM_SUB), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .CASCADE_LINE(CASCADE_LINE), .PEND_OFS(PEND_OFS), .MASK_OFS(MASK_OFS), .FLAG_OFS(FLAG_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .sub_irq(sub_irq),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rvalid(bus_rvalid), .cpu_irq(cpu_irq),
  .pend_q(pend_q), .mask_q(mask_q), .flags_q(flags_q)
);

// File: tb/tgl_irq_ctrl_test.sv
module tgl_irq_ctrl_test;
  localparam logic [15:0] A_PEND = 16'hF000;
  localparam logic [15:0] A_MASK = 16'hF010;
  localparam logic [15:0] A_FLAG = 16'hF230;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_lines = '0;
  logic [1:0]  sub_irq = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        cpu_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tgl_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .sub_irq(sub_irq),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .cpu_irq(cpu_irq)
  );

  // behavioural reference
  int unsigned m_pend, m_mask, m_flag, m_rdata;
  bit m_rvalid;

  always @(posedge clk) begin
    int unsigned np, nm, nf, lines, sel_v;
    if (!rst_n) begin
      m_pend = 0; m_mask = 0; m_flag = 0; m_rvalid = 0; m_rdata = 0;
    end else begin
      sel_v = 0;
      if (bus_addr == A_PEND) sel_v = m_pend;
      else if (bus_addr == A_MASK) sel_v = m_mask;
      else if (bus_addr == A_FLAG) sel_v = m_flag;
      m_rvalid = bus_rd;
      if (bus_rd) m_rdata = sel_v;
      lines = irq_lines;
      if (m_flag != 0) lines = lines | 2;
      np = lines;
      if (bus_wr && bus_addr == A_PEND) np = np & ~(bus_wdata & 32'hFFFF);
      nm = m_mask;
      if (bus_wr && bus_addr == A_MASK) nm = nm ^ (bus_wdata & 32'hFFFF);
      nf = (sub_irq[0] ? 32'h100 : 0) | (sub_irq[1] ? 32'h400 : 0);
      if (bus_wr && bus_addr == A_FLAG) nf = nf & ~bus_wdata;
      m_pend = np; m_mask = nm; m_flag = nf;
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // per-cycle comparison against the model (R3, R6)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3", {31'd0, cpu_irq}, {31'd0, ((m_pend & m_mask) != 0)});
      chk("R6", {31'd0, bus_rvalid}, {31'd0, m_rvalid});
      if (m_rvalid) chk("R6", bus_rdata, m_rdata);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [15:0] a, logic [31:0] exp, string req);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    chk(req, bus_rdata, exp);
  endtask

  task automatic rdwr(logic [15:0] a, logic [31:0] d, logic [31:0] exp, string req);
    bus_rd = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_rd = 0; bus_wr = 0;
    chk(req, bus_rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1;
    // R1: reset state
    chk("R1", {31'd0, cpu_irq}, 32'd0);
    rd(A_PEND, 32'h0, "R1");
    rd(A_MASK, 32'h0, "R1");
    rd(A_FLAG, 32'h0, "R1");
    // R2: pending follows lines
    irq_lines = 16'h00A5;
    idle(2);
    rd(A_PEND, 32'h00A5, "R2");
    chk("R3", {31'd0, cpu_irq}, 32'd0);
    // R5: toggle mask
    wr(A_MASK, 32'h0005);
    rd(A_MASK, 32'h0005, "R5");
    wr(A_MASK, 32'h0003);
    rd(A_MASK, 32'h0006, "R5");
    chk("R3", {31'd0, cpu_irq}, 32'd1);
    // R6: read does not clear
    rd(A_PEND, 32'h00A5, "R6");
    rd(A_PEND, 32'h00A5, "R6");
    irq_lines = 16'h0000;
    idle(2);
    rd(A_PEND, 32'h0000, "R2");
    chk("R3", {31'd0, cpu_irq}, 32'd0);
    // R4: clear with held source, read in write cycle gives old value
    irq_lines = 16'h0004;
    idle(2);
    rdwr(A_PEND, 32'h0004, 32'h0004, "R6");
    rd(A_PEND, 32'h0000, "R4");
    rd(A_PEND, 32'h0004, "R4");
    irq_lines = 16'h0000;
    // R7, R9: cascade
    sub_irq = 2'b01;
    idle(3);
    rd(A_FLAG, 32'h0100, "R7");
    rd(A_PEND, 32'h0002, "R9");
    chk("R9", {31'd0, cpu_irq}, 32'd1);
    sub_irq = 2'b11;
    idle(2);
    rd(A_FLAG, 32'h0500, "R7");
    // R8: write-1 clear on flags
    wr(A_FLAG, 32'h0400);
    rd(A_FLAG, 32'h0100, "R8");
    rd(A_FLAG, 32'h0500, "R8");
    sub_irq = 2'b00;
    idle(3);
    rd(A_PEND, 32'h0000, "R9");
    // R10: other addresses
    wr(16'h1234, 32'hFFFF_FFFF);
    rd(A_MASK, 32'h0006, "R10");
    rd(16'h1234, 32'h0, "R10");
    // random phase, compared cycle by cycle
    for (int i = 0; i < 400; i++) begin
      int op;
      irq_lines = 16'($urandom);
      sub_irq = 2'($urandom);
      op = $urandom_range(0, 5);
      bus_addr = (op % 4 == 0) ? A_PEND : (op % 4 == 1) ? A_MASK :
                 (op % 4 == 2) ? A_FLAG : 16'($urandom);
      bus_wdata = $urandom;
      bus_wr = $urandom_range(0, 2) == 0;
      bus_rd = $urandom_range(0, 1) == 0;
      @(negedge clk);
    end
    bus_wr = 0; bus_rd = 0;
    idle(2);
    finish_run();
  end
endmodule